// File: doc/BRIEF.md
# Key-Protected System Control Registers

This block is a small system-control register file. Two of its registers drive chip-wide settings: a device-configuration word that steers pin multiplexing and peripheral enables, and a clock-divider word. Both are guarded by a key. Software first writes the unlock key to the lock register. The very next register write then lands, and the guard closes again by itself. Any other write to a guarded register is discarded, and a sticky violation flag records it until software reads that flag.

A read-only identity register reports the chip revision, which comes in on an input pin. One bit of the device-configuration word acts as a software reset control. Setting that bit and then clearing it produces a single-cycle reset request on an output.

Requests arrive on a valid/ready channel. Read data leaves on a second valid/ready channel that can apply back-pressure. While a read result is waiting and the consumer is not taking it, the request channel stops accepting. Writes produce no response.

Top module: `swlock_sysctl`

## Requirements
- R1: After reset, `devcfg_o` and `clkdiv_o` hold their reset values (zero by default), the registers are locked, `rsp_valid` is low and `sw_reset_req` is low.
- R2: An accepted write of exactly 0x000000AA to the lock register (word address 0) unlocks the guarded registers. A read of the lock register returns 1 in bit 0 while unlocked and 0 while locked, with all other bits zero.
- R3: While unlocked, an accepted write to the device-configuration register (address 1) or the clock-divider register (address 2) updates it, and the output reflects the new value from the next cycle.
- R4: Any accepted write that is not a key write relocks the registers. This covers writes to unguarded or unmapped addresses and writes to the lock register with a value other than the key. Reads never change the lock state.
- R5: A write to a guarded register while locked leaves that register and its output unchanged and sets the violation flag, which is bit 0 of the status register (address 4).
- R6: A read of the status register returns the violation flag and clears it, so an immediate second read returns 0.
- R7: Reads of the device-configuration and clock-divider registers return their current values.
- R8: The identity register (address 3) returns `chip_rev` in bits 31:28 and zero elsewhere. Writes to it change nothing and do not set the violation flag.
- R9: When bit 31 of the device-configuration register goes from 1 to 0, `sw_reset_req` is high for exactly the one cycle after the write is accepted. Setting the bit produces no pulse.
- R10: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A read gives `rsp_valid` in the next cycle, and `rsp_rdata` stays valid and stable until `rsp_ready` is high. `req_ready` equals `!rsp_valid || rsp_ready`, and an accepted write is followed by no response.
- R11: Reads of unmapped addresses (5 and above) return zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (4) | Word address |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_rdata | output | DATA_W (32) | Read data |
| chip_rev | input | REV_W (4) | Revision value reported by the identity register |
| devcfg_o | output | DATA_W (32) | Device-configuration word |
| clkdiv_o | output | DATA_W (32) | Clock-divider word |
| sw_reset_req | output | 1 | One-cycle software reset request |

## Verification
A lock flag stuck open shows up on the first read of the lock register, which returns 1 where 0 is expected. It also shows up on the following guarded write, which lands when it should be dropped and changes `devcfg_o` or `clkdiv_o` one cycle after acceptance. A flag stuck closed loses the protected write in that same cycle. A wrong violation flag appears on the next status read. A faulty edge detector for the reset bit either misses its pulse or holds it, and the output check made one cycle after the clearing write exposes this.

// File: rtl/swl_pkg.sv
`timescale 1ns/1ps
package swl_pkg;
  localparam int unsigned ADR_LOCK   = 0;
  localparam int unsigned ADR_DEVCFG = 1;
  localparam int unsigned ADR_CLKDIV = 2;
  localparam int unsigned ADR_SYSID  = 3;
  localparam int unsigned ADR_STATUS = 4;

  typedef struct packed {
    logic lock;
    logic devcfg;
    logic clkdiv;
    logic sysid;
    logic status;
  } hit_t;
endpackage

// File: rtl/swl_decode.sv
`timescale 1ns/1ps
module swl_decode
  import swl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_t              hit
);
  always_comb begin
    hit        = '0;
    hit.lock   = (addr == ADDR_W'(ADR_LOCK));
    hit.devcfg = (addr == ADDR_W'(ADR_DEVCFG));
    hit.clkdiv = (addr == ADDR_W'(ADR_CLKDIV));
    hit.sysid  = (addr == ADDR_W'(ADR_SYSID));
    hit.status = (addr == ADDR_W'(ADR_STATUS));
  end
endmodule

// File: rtl/swl_keygate.sv
`timescale 1ns/1ps
module swl_keygate #(
  parameter int                 DATA_W     = 32,
  parameter logic [DATA_W-1:0]  UNLOCK_KEY = 'hAA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_fire,
  input  logic              wr_lock,
  input  logic              wr_guarded,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_status,
  output logic              unlocked,
  output logic              grant,
  output logic              viol
);
  logic key_seen;
  assign key_seen = wr_fire & wr_lock & (wdata == UNLOCK_KEY);
  assign grant    = wr_fire & wr_guarded & unlocked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (key_seen) begin
      unlocked <= 1'b1;
    end else if (wr_fire) begin
      unlocked <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol <= 1'b0;
    end else if (wr_fire & wr_guarded & ~unlocked) begin
      viol <= 1'b1;
    end else if (rd_status) begin
      viol <= 1'b0;
    end
  end
endmodule

// File: rtl/swl_protregs.sv
`timescale 1ns/1ps
module swl_protregs #(
  parameter int                        DATA_W = 32,
  parameter int                        NREG   = 2,
  parameter logic [NREG*DATA_W-1:0]    INIT   = '0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NREG-1:0]               we,
  input  logic [DATA_W-1:0]             wdata,
  output logic [NREG-1:0][DATA_W-1:0]   q
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        q[g] <= INIT[g*DATA_W +: DATA_W];
      end else if (we[g]) begin
        q[g] <= wdata;
      end
    end
  end
endmodule

// File: rtl/swl_rstpulse.sv
`timescale 1ns/1ps
module swl_rstpulse #(
  parameter logic INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_bit,
  output logic pulse
);
  logic prev_q;
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= INIT;
    else        prev_q <= ctl_bit;
  end
  assign pulse = prev_q & ~ctl_bit;
endmodule

// File: rtl/swl_rspstage.sv
`timescale 1ns/1ps
module swl_rspstage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] ldata,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              can_accept
);
  assign can_accept = ~rsp_valid | rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= ldata;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/swlock_sysctl.sv
`timescale 1ns/1ps
module swlock_sysctl
  import swl_pkg::*;
#(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 4,
  parameter logic [DATA_W-1:0] UNLOCK_KEY  = 'hAA,
  parameter logic [DATA_W-1:0] DEVCFG_INIT = '0,
  parameter logic [DATA_W-1:0] CLKDIV_INIT = '0,
  parameter int                SWRST_BIT   = 31,
  parameter int                REV_W       = 4,
  parameter int                REV_LSB     = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [REV_W-1:0]  chip_rev,
  output logic [DATA_W-1:0] devcfg_o,
  output logic [DATA_W-1:0] clkdiv_o,
  output logic              sw_reset_req
);
  localparam int NPROT = 2;
  localparam int IDX_DEVCFG = 0;
  localparam int IDX_CLKDIV = 1;
  localparam logic [NPROT*DATA_W-1:0] PROT_INIT = {CLKDIV_INIT, DEVCFG_INIT};

  hit_t hit;
  logic req_fire, wr_fire, rd_fire, guarded;
  logic unlocked, grant, viol;
  logic [NPROT-1:0] prot_we;
  logic [NPROT-1:0][DATA_W-1:0] prot_q;
  logic [DATA_W-1:0] rd_mux;

  swl_decode #(.ADDR_W(ADDR_W)) u_dec (.addr(req_addr), .hit(hit));

  assign req_fire = req_valid & req_ready;
  assign wr_fire  = req_fire & req_write;
  assign rd_fire  = req_fire & ~req_write;
  assign guarded  = hit.devcfg | hit.clkdiv;

  swl_keygate #(.DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .wr_lock(hit.lock),
    .wr_guarded(guarded), .wdata(req_wdata), .rd_status(rd_fire & hit.status),
    .unlocked(unlocked), .grant(grant), .viol(viol)
  );

  assign prot_we[IDX_DEVCFG] = grant & hit.devcfg;
  assign prot_we[IDX_CLKDIV] = grant & hit.clkdiv;

  swl_protregs #(.DATA_W(DATA_W), .NREG(NPROT), .INIT(PROT_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(prot_we), .wdata(req_wdata), .q(prot_q)
  );

  assign devcfg_o = prot_q[IDX_DEVCFG];
  assign clkdiv_o = prot_q[IDX_CLKDIV];

  swl_rstpulse #(.INIT(DEVCFG_INIT[SWRST_BIT])) u_rst (
    .clk(clk), .rst_n(rst_n), .ctl_bit(devcfg_o[SWRST_BIT]), .pulse(sw_reset_req)
  );

  always_comb begin
    rd_mux = '0;
    if (hit.lock)   rd_mux = DATA_W'(unlocked);
    if (hit.devcfg) rd_mux = devcfg_o;
    if (hit.clkdiv) rd_mux = clkdiv_o;
    if (hit.sysid)  rd_mux = DATA_W'(chip_rev) << REV_LSB;
    if (hit.status) rd_mux = DATA_W'(viol);
  end

  swl_rspstage #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load(rd_fire), .ldata(rd_mux),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .can_accept(req_ready)
  );
endmodule

// File: rtl/swlock_sysctl_chk.sv
`timescale 1ns/1ps
module swlock_sysctl_chk
  import swl_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter int                ADDR_W     = 4,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 'hAA,
  parameter int                SWRST_BIT  = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [DATA_W-1:0] devcfg_o,
  input logic              sw_reset_req,
  input logic              unlocked
);
  logic wr_acc, key_wr;
  assign wr_acc = req_valid & req_ready & req_write;
  assign key_wr = wr_acc & (req_addr == ADDR_W'(ADR_LOCK)) & (req_wdata == UNLOCK_KEY);

  AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    key_wr |=> unlocked); // R2
  AST_WRITE_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !key_wr) |=> !unlocked); // R4
  AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == ADDR_W'(ADR_DEVCFG) && !unlocked) |=> $stable(devcfg_o)); // R5
  AST_PULSE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devcfg_o[SWRST_BIT]) |-> sw_reset_req); // R9
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset_req |=> !sw_reset_req); // R9
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata))); // R10
  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready); // R10
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !rsp_valid); // R10
endmodule

bind swlock_sysctl swlock_sysctl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY), .SWRST_BIT(SWRST_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .devcfg_o(devcfg_o), .sw_reset_req(sw_reset_req), .unlocked(unlocked)
);

// File: tb/swlock_sysctl_test.sv
`timescale 1ns/1ps
module swlock_sysctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic [3:0]  chip_rev = 4'h0;
  logic [31:0] devcfg_o, clkdiv_o;
  logic        sw_reset_req;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  swlock_sysctl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .chip_rev(chip_rev), .devcfg_o(devcfg_o), .clkdiv_o(clkdiv_o),
    .sw_reset_req(sw_reset_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic w, input logic [3:0] a, input logic [31:0] d,
                       input logic [31:0] exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (!w) begin exp_q.push_back(exp); tag_q.push_back(tag); end
    #0.5 req_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    issue(1'b1, a, d, 32'h0, "");
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    issue(1'b0, a, 32'h0, exp, tag);
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  // scoreboard monitor: pops an expectation whenever a response is taken
  always @(negedge clk) begin
    #2;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        chk(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    chk("R1 devcfg reset", devcfg_o, 32'h0);
    chk("R1 clkdiv reset", clkdiv_o, 32'h0);
    chk("R1 rsp_valid reset", {31'b0, rsp_valid}, 32'h0);
    chk("R1 sw_reset_req reset", {31'b0, sw_reset_req}, 32'h0);
    rd(4'd0, 32'h0, "R1 locked after reset");

    // R5/R6: locked write dropped, violation flagged then cleared by read
    wr(4'd1, 32'h0000_1234);
    settle();
    chk("R5 devcfg unchanged", devcfg_o, 32'h0);
    chk("R10 write gives no response", {31'b0, rsp_valid}, 32'h0);
    rd(4'd4, 32'h1, "R5 violation set");
    rd(4'd4, 32'h0, "R6 violation cleared by read");

    // R2/R3/R4/R7: key then protected write
    wr(4'd0, 32'h0000_00AA);
    rd(4'd0, 32'h1, "R2 unlocked reads 1");
    rd(4'd0, 32'h1, "R4 read does not relock");
    wr(4'd1, 32'h0000_00F0);
    settle();
    chk("R3 devcfg written", devcfg_o, 32'h0000_00F0);
    rd(4'd0, 32'h0, "R3 relocked after protected write");
    rd(4'd1, 32'h0000_00F0, "R7 devcfg readback");
    rd(4'd4, 32'h0, "R3 no violation");

    wr(4'd0, 32'h0000_00AA);
    wr(4'd2, 32'h0000_0055);
    settle();
    chk("R3 clkdiv written", clkdiv_o, 32'h0000_0055);
    rd(4'd2, 32'h0000_0055, "R7 clkdiv readback");

    // R8/R4: write to identity after key relocks and is ignored
    wr(4'd0, 32'h0000_00AA);
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd0, 32'h0, "R4 identity write relocks");
    rd(4'd4, 32'h0, "R8 identity write no violation");
    wr(4'd2, 32'h0000_0077);
    settle();
    chk("R4 clkdiv held after relock", clkdiv_o, 32'h0000_0055);
    rd(4'd4, 32'h1, "R5 violation after relock");

    // R4: wrong key relocks; R11 unmapped
    wr(4'd0, 32'h0000_00AA);
    wr(4'd0, 32'h0000_01AA);
    rd(4'd0, 32'h0, "R4 wrong key relocks");
    wr(4'd0, 32'h0000_00AA);
    wr(4'd9, 32'h0000_0005);
    rd(4'd0, 32'h0, "R11 unmapped write relocks");
    rd(4'd9, 32'h0, "R11 unmapped reads zero");
    settle();
    chk("R11 devcfg untouched", devcfg_o, 32'h0000_00F0);
    chk("R11 clkdiv untouched", clkdiv_o, 32'h0000_0055);

    chip_rev = 4'hA;
    rd(4'd3, 32'hA000_0000, "R8 revision field");

    // R9: setting reset bit gives no pulse, clearing it gives one
    wr(4'd0, 32'h0000_00AA);
    wr(4'd1, 32'h8000_00F0);
    settle();
    chk("R9 no pulse on set", {31'b0, sw_reset_req}, 32'h0);
    chk("R9 devcfg bit set", devcfg_o, 32'h8000_00F0);
    settle();
    chk("R9 still no pulse", {31'b0, sw_reset_req}, 32'h0);
    wr(4'd0, 32'h0000_00AA);
    wr(4'd1, 32'h0000_00F0);
    settle();
    chk("R9 pulse on clear", {31'b0, sw_reset_req}, 32'h1);
    settle();
    chk("R9 pulse one cycle", {31'b0, sw_reset_req}, 32'h0);

    // R10: back-pressure on the response channel
    @(negedge clk); rsp_ready = 1'b0;
    rd(4'd1, 32'h0000_00F0, "R10 stalled read data");
    settle();
    chk("R10 rsp_valid while stalled", {31'b0, rsp_valid}, 32'h1);
    chk("R10 req_ready low while stalled", {31'b0, req_ready}, 32'h0);
    chk("R10 data while stalled", rsp_rdata, 32'h0000_00F0);
    repeat (3) settle();
    chk("R10 data held", rsp_rdata, 32'h0000_00F0);
    chk("R10 valid held", {31'b0, rsp_valid}, 32'h1);
    @(negedge clk); rsp_ready = 1'b1;
    repeat (3) settle();
    chk("R10 response drained", {31'b0, rsp_valid}, 32'h0);
    chk("R10 all responses seen", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule